// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN identifier should be kept and, if so, which receive buffer it belongs to. It holds a table of filter slots. Each slot stores a reference identifier, a per-bit care mask, an enable bit and a frame-format bit. A mask bit at 1 means that identifier position is compared. A mask bit at 0 makes that position a don't-care, so one slot can accept a whole family of identifiers. A mask can leave every bit checked or only some of them.

The frame parser presents the received identifier, its IDE (extended-format) flag and a one-cycle valid strobe. One clock later the filter reports whether any slot accepted the identifier, and which slot did. Software loads the table through a simple write port that selects a slot and one of its three fields.

Top module: `id_accept_filter`

## Requirements
- R1: After reset, resultValid, hit and bufIdx are all 0, and every slot is disabled, so no identifier is accepted until a slot is enabled.
- R2: resultValid is 1 in exactly the clock cycle after a cycle in which idValid is 1, and 0 in every other cycle.
- R3: A slot matches when every identifier bit whose mask bit is 1 equals the slot's stored bit. Bits whose mask bit is 0 are ignored.
- R4: For an extended frame (rxIde=1), all 29 bits rxId[28:0] take part in the comparison. For a standard frame (rxIde=0), only rxId[10:0] takes part, and rxId[28:11] and the slot's upper bits are ignored.
- R5: A slot matches only when its format bit equals rxIde.
- R6: A slot whose enable bit is 0 never matches.
- R7: When several slots match, hit is 1 and bufIdx is the lowest matching slot index.
- R8: When no slot matches, the result has hit=0 and bufIdx=0.
- R9: A table write in the same cycle as idValid does not affect that evaluation. It does apply to the next evaluation.
- R10: A write with wrEn=1 stores wrData into slot wrSlot. The field is chosen by wrSel: 0 writes the identifier (wrData[28:0]), 1 writes the mask (wrData[28:0]), and 2 writes the configuration (wrData[0]=enable, wrData[1]=format bit). wrSel=3 changes nothing.
- R11: hit and bufIdx keep their last values in every cycle where resultValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| idValid | input | 1 | Strobe: rxId and rxIde are valid |
| rxId | input | 29 | Received identifier; standard identifiers occupy bits [10:0] |
| rxIde | input | 1 | 1 = extended frame, 0 = standard frame |
| wrEn | input | 1 | Table write strobe |
| wrSel | input | 2 | Field select: 0 identifier, 1 mask, 2 configuration, 3 none |
| wrSlot | input | 3 | Slot index for the write |
| wrData | input | 29 | Write data |
| resultValid | output | 1 | Result strobe, one cycle after idValid |
| hit | output | 1 | The identifier was accepted by some slot |
| bufIdx | output | 3 | Index of the accepting slot |

## Verification
Every filter result is due exactly one clock edge after the idValid strobe. The table is registered, so a write issued on a given edge is first seen by an evaluation presented on the following edge. The bench drives inputs on the falling edge and samples outputs on the next falling edge, which places each check half a cycle after the edge that produced the result. It also checks the cycle after that, where resultValid must be 0 and the outputs must hold. The expected hit and index come from a software copy of the table, which the bench updates only after the write edge. This lets the same-cycle write case be predicted against the old table contents.

// File: rtl/idf_pkg.sv
package idf_pkg;

  typedef enum logic [1:0] {
    SEL_ID   = 2'd0,
    SEL_MASK = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_NONE = 2'd3
  } wrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic eval;
    logic wrId;
    logic wrMask;
    logic wrCfg;
  } idfStrobe_t;

endpackage

// File: rtl/idf_ctrl.sv
module idf_ctrl
  import idf_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idValid,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [SLOT_W-1:0] wrSlot,
  output idfStrobe_t        strb
);

  logic   slotOk;
  wrSel_e selField;

  assign selField = wrSel_e'(wrSel);
  assign slotOk   = {1'b0, wrSlot} < (SLOT_W+1)'(NUM_SLOTS);

  always_comb begin
    strb        = '0;
    strb.eval   = idValid;
    if (wrEn && slotOk) begin
      unique case (selField)
        SEL_ID:   strb.wrId   = 1'b1;
        SEL_MASK: strb.wrMask = 1'b1;
        SEL_CFG:  strb.wrCfg  = 1'b1;
        default:  ;
      endcase
    end
  end

  // R10: at most one field write strobe per cycle, none without wrEn
  assert_one_field_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrId, strb.wrMask, strb.wrCfg}));
  assert_no_stray_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(strb.wrId || strb.wrMask || strb.wrCfg));

endmodule

// File: rtl/idf_slot_cmp.sv
module idf_slot_cmp #(
  parameter int ID_W     = 29,
  parameter int STD_ID_W = 11
) (
  input  logic [ID_W-1:0] rxId,
  input  logic            rxIde,
  input  logic [ID_W-1:0] cfgId,
  input  logic [ID_W-1:0] cfgMask,
  input  logic            cfgEn,
  input  logic            cfgIde,
  output logic            match
);

  localparam int UPPER_W = ID_W - STD_ID_W;

  logic [ID_W-1:0] fmtMask;
  logic [ID_W-1:0] diffBits;

  // standard frames only look at the low identifier bits
  assign fmtMask  = rxIde ? {ID_W{1'b1}} : {{UPPER_W{1'b0}}, {STD_ID_W{1'b1}}};
  assign diffBits = (rxId ^ cfgId) & cfgMask & fmtMask;
  assign match    = cfgEn && (cfgIde == rxIde) && (diffBits == '0);

endmodule

// File: rtl/idf_datapath.sv
module idf_datapath
  import idf_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int ID_W      = 29,
  parameter int STD_ID_W  = 11,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  idfStrobe_t        strb,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [ID_W-1:0]   wrData,
  input  logic [ID_W-1:0]   rxId,
  input  logic              rxIde,
  output logic              resultValid,
  output logic              hit,
  output logic [SLOT_W-1:0] bufIdx
);

  logic [ID_W-1:0]      slotId   [NUM_SLOTS];
  logic [ID_W-1:0]      slotMask [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slotEn;
  logic [NUM_SLOTS-1:0] slotIde;
  logic [NUM_SLOTS-1:0] matchVec;
  logic                 anyHit;
  logic [SLOT_W-1:0]    winIdx;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    logic selMe;
    assign selMe = (wrSlot == SLOT_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotId[g]   <= '0;
        slotMask[g] <= '0;
        slotEn[g]   <= 1'b0;
        slotIde[g]  <= 1'b0;
      end else if (selMe) begin
        if (strb.wrId)   slotId[g]   <= wrData;
        if (strb.wrMask) slotMask[g] <= wrData;
        if (strb.wrCfg) begin
          slotEn[g]  <= wrData[0];
          slotIde[g] <= wrData[1];
        end
      end
    end

    idf_slot_cmp #(.ID_W(ID_W), .STD_ID_W(STD_ID_W)) u_cmp (
      .rxId   (rxId),
      .rxIde  (rxIde),
      .cfgId  (slotId[g]),
      .cfgMask(slotMask[g]),
      .cfgEn  (slotEn[g]),
      .cfgIde (slotIde[g]),
      .match  (matchVec[g])
    );
  end

  // lowest index has priority
  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        anyHit = 1'b1;
        winIdx = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      hit         <= 1'b0;
      bufIdx      <= '0;
    end else begin
      resultValid <= strb.eval;
      if (strb.eval) begin
        hit    <= anyHit;
        bufIdx <= winIdx;
      end
    end
  end

  assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.eval |=> resultValid);
  assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.eval |=> !resultValid);
  assert_hit_slot_enabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && hit) |-> |(($past(slotEn) >> bufIdx) & NUM_SLOTS'(1)));
  assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && hit) |->
      (($past(matchVec) & ((NUM_SLOTS'(1) << bufIdx) - NUM_SLOTS'(1))) == '0));
  assert_miss_index_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !hit) |-> (bufIdx == '0));
  assert_hold_outputs_R11: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> ($stable(hit) && $stable(bufIdx)));

endmodule

// File: rtl/id_accept_filter.sv
module id_accept_filter
  import idf_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int ID_W      = 29,
  parameter int STD_ID_W  = 11,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idValid,
  input  logic [ID_W-1:0]   rxId,
  input  logic              rxIde,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [ID_W-1:0]   wrData,
  output logic              resultValid,
  output logic              hit,
  output logic [SLOT_W-1:0] bufIdx
);

  idfStrobe_t strb;

  idf_ctrl #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .idValid(idValid),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrSlot (wrSlot),
    .strb   (strb)
  );

  idf_datapath #(
    .NUM_SLOTS(NUM_SLOTS),
    .ID_W     (ID_W),
    .STD_ID_W (STD_ID_W),
    .SLOT_W   (SLOT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrSlot     (wrSlot),
    .wrData     (wrData),
    .rxId       (rxId),
    .rxIde      (rxIde),
    .resultValid(resultValid),
    .hit        (hit),
    .bufIdx     (bufIdx)
  );

endmodule

// File: tb/sim_id_accept_filter.sv
module sim_id_accept_filter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        idValid = 1'b0;
  logic [28:0] rxId = '0;
  logic        rxIde = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [2:0]  wrSlot = '0;
  logic [28:0] wrData = '0;
  logic        resultValid;
  logic        hit;
  logic [2:0]  bufIdx;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [28:0] mId [8];
  logic [28:0] mMask [8];
  bit          mEn [8];
  bit          mIde [8];
  bit          lastHit = 0;
  int          lastIdx = 0;

  always #2 clk = ~clk;

  id_accept_filter u0 (
    .clk(clk), .rstN(rstN), .idValid(idValid), .rxId(rxId), .rxIde(rxIde),
    .wrEn(wrEn), .wrSel(wrSel), .wrSlot(wrSlot), .wrData(wrData),
    .resultValid(resultValid), .hit(hit), .bufIdx(bufIdx)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void refEval(input logic [28:0] id, input bit ide,
                                  output bit h, output int idx);
    logic [28:0] fm;
    fm = ide ? 29'h1FFFFFFF : 29'h000007FF;
    h = 0;
    idx = 0;
    for (int s = 0; s < 8; s++) begin
      if (!h && mEn[s] && (mIde[s] == ide) && (((id ^ mId[s]) & mMask[s] & fm) == 0)) begin
        h = 1;
        idx = s;
      end
    end
  endfunction

  function automatic void modelWrite(int slot, int sel, logic [28:0] data);
    case (sel)
      0: mId[slot] = data;
      1: mMask[slot] = data;
      2: begin mEn[slot] = data[0]; mIde[slot] = data[1]; end
      default: ;
    endcase
  endfunction

  task automatic doWrite(int slot, int sel, logic [28:0] data);
    @(negedge clk);
    wrEn = 1; wrSlot = 3'(slot); wrSel = 2'(sel); wrData = data;
    @(negedge clk);
    wrEn = 0;
    modelWrite(slot, sel, data);
  endtask

  // evaluation, optionally with a simultaneous table write (R9)
  task automatic doEval(logic [28:0] id, bit ide, string req,
                        bit withWr = 0, int slot = 0, int sel = 3, logic [28:0] data = '0);
    bit eh;
    int ei;
    refEval(id, ide, eh, ei);
    @(negedge clk);
    idValid = 1; rxId = id; rxIde = ide;
    if (withWr) begin
      wrEn = 1; wrSlot = 3'(slot); wrSel = 2'(sel); wrData = data;
    end
    @(negedge clk);
    idValid = 0; wrEn = 0;
    if (withWr) modelWrite(slot, sel, data);
    check(resultValid == 1, {req, " R2 valid"}, int'(resultValid), 1);
    check(hit == eh, {req, " hit"}, int'(hit), int'(eh));
    check(int'(bufIdx) == ei, {req, " idx"}, int'(bufIdx), ei);
    lastHit = eh; lastIdx = ei;
    rxId = 29'h15555555; rxIde = ~ide;
    @(negedge clk);
    check(resultValid == 0, "R2 single pulse", int'(resultValid), 0);
    check(hit == lastHit && int'(bufIdx) == lastIdx, "R11 hold",
          int'(bufIdx), lastIdx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r;
    for (int s = 0; s < 8; s++) begin
      mId[s] = '0; mMask[s] = '0; mEn[s] = 0; mIde[s] = 0;
    end
    r = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check(resultValid == 0 && hit == 0 && bufIdx == 0, "R1 reset outputs",
          int'({resultValid, hit, bufIdx}), 0);
    rstN = 1;
    @(negedge clk);
    doEval(29'h0, 0, "R1 all disabled");
    doEval(29'h0, 1, "R1 all disabled ext");

    // slot 3: standard 0x123, all standard bits checked
    doWrite(3, 0, 29'h123);
    doWrite(3, 1, 29'h7FF);
    doWrite(3, 2, 29'h1);
    doEval(29'h123, 0, "R3 exact std");
    doEval(29'h124, 0, "R8 miss");
    doEval(29'h123, 1, "R5 wrong format");
    doEval({18'h3FFFF, 11'h123}, 0, "R4 upper ignored std");

    // slot 5: extended group, low 8 bits don't care
    doWrite(5, 0, 29'h1ABCDE00);
    doWrite(5, 1, 29'h1FFFFF00);
    doWrite(5, 2, 29'h3);
    doEval(29'h1ABCDE7F, 1, "R3 group ext");
    doEval(29'h1ABCDF00, 1, "R4 ext bit8 compared");
    doEval(29'h0ABCDE00, 1, "R4 ext bit28 compared");

    // slot 1 overlaps slot 5
    doWrite(1, 0, 29'h1ABCDE55);
    doWrite(1, 1, 29'h1FFFFFFF);
    doWrite(1, 2, 29'h3);
    doEval(29'h1ABCDE55, 1, "R7 lowest wins");
    doWrite(1, 2, 29'h2);
    doEval(29'h1ABCDE55, 1, "R6 disabled slot skipped");
    check(int'(bufIdx) == 5, "R7 fallback to slot 5", int'(bufIdx), 5);

    // wrSel 3 must not change slot 5
    doWrite(5, 3, 29'h0);
    doEval(29'h1ABCDE7F, 1, "R10 sel3 no effect");
    check(hit == 1, "R10 sel3 keeps slot", int'(hit), 1);

    // write during evaluation
    doEval(29'h1ABCDE7F, 1, "R9 same-cycle write old table", 1, 5, 2, 29'h0);
    check(hit == 1, "R9 old table used", int'(hit), 1);
    doEval(29'h1ABCDE7F, 1, "R9 write seen next");
    check(hit == 0, "R9 new table used", int'(hit), 0);

    // random phase
    for (int s = 0; s < 8; s++) begin
      doWrite(s, 0, 29'($urandom()));
      doWrite(s, 1, 29'($urandom()) | 29'h1E00003);
      doWrite(s, 2, 29'($urandom() % 4) | 29'h1);
    end
    for (int it = 0; it < 150; it++) begin
      int s;
      bit ide;
      logic [28:0] id;
      if ($urandom() % 4 == 0)
        doWrite(int'($urandom() % 8), int'($urandom() % 4),
                29'($urandom()) | 29'h1);
      s = int'($urandom() % 8);
      ide = ($urandom() % 3 != 0) ? mIde[s] : ~mIde[s];
      if ($urandom() % 5 == 0) id = 29'($urandom());
      else id = mId[s] ^ (29'($urandom()) & ~mMask[s]);
      if (it % 10 == 0)
        doEval(id, ide, "R3 R7 random with write", 1, int'($urandom() % 8),
               int'($urandom() % 4), 29'($urandom()));
      else
        doEval(id, ide, "R3 R5 R7 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule